// File: doc/BRIEF.md
# Programmable Stream Delay Line

This block delays a synchronous word stream by a number of clock cycles chosen when the stream starts, from zero up to one less than the depth of its internal store. A one-cycle start pulse captures the delay setting and clears the write position. From the next cycle on, one input word is accepted on every clock. Each word reappears on the output exactly the programmed number of cycles later, and a valid flag marks those cycles.

Storage is a small register array with one write port and one read port. The read position is loaded with the delay, counts down while the first words are stored, and counts up once it reaches zero. At that point it trails the write position by exactly the delay, so the two ports never meet on the same location. A delay of zero routes the input straight to the output without touching the array.

A stop request ends the intake. Words already stored are still read out on their normal schedule, after which the block falls idle. A new start pulse at any time discards whatever is in flight and begins a fresh stream.

Top module: `prog_stream_delay`

## Requirements
- R1: After reset, and whenever no stream is active, valid_o is 0 and dout_o is 0.
- R2: With a captured delay D from 1 to 15, the word driven on din_i in the n-th cycle after the start cycle (n = 0 first) appears on dout_o with valid_o = 1 in cycle n + D.
- R3: With a captured delay of 0, dout_o equals din_i in the same cycle and valid_o is 1 in every running cycle after the start cycle.
- R4: In the start cycle, and in the first D cycles after it, valid_o is 0.
- R5: A stop_i pulse in a running cycle s stores neither that cycle's word nor any later word. Words from cycles before s still emerge with latency D. After the last of them, valid_o stays 0 until the next start.
- R6: dly_i is sampled only in a start cycle. Changing it while a stream runs or drains leaves the latency unchanged.
- R7: dout_o is 0 in every cycle where valid_o is 0.
- R8: A start pulse while a stream is running or draining discards all stored words and restarts the stream with the newly sampled delay. Its first output is the first word after the new start.
- R9: stop_i has no effect while the block is idle or already draining. It neither cuts the drain short nor produces output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are synchronous to it |
| rst | input | 1 | Synchronous active-high reset to idle |
| start_i | input | 1 | One-cycle pulse that begins a new stream |
| stop_i | input | 1 | Ends the intake; stored words still drain |
| dly_i | input | 4 | Delay in cycles, captured in the start cycle |
| din_i | input | 4 | Input word stream |
| dout_o | output | 4 | Delayed word, 0 when not valid |
| valid_o | output | 1 | High in cycles that carry a delayed word |

## Verification
The interesting collision is a stop request in the same cycle as a delayed word leaves the array. The read for an older word must still happen while the write of the current word is suppressed. A stop inside the countdown window, before any read has begun, is the harder variant. The bench places stop pulses at random offsets, including cycle zero and cycles just before, at and after the delay, across delays of 0, 1, 15 and random values. Extra stop and start pulses land during the drain. A bench model is built only from the stated latency rule and the stop index. It predicts valid_o and dout_o in every cycle, and any early, late, missing or extra word is reported.

// File: rtl/psd_pkg.sv
package psd_pkg;
   typedef enum logic [1:0] {
      PS_IDLE  = 2'd0,
      PS_RUN   = 2'd1,
      PS_DRAIN = 2'd2
   } psd_state_e;
endpackage

// File: rtl/psd_mem.sv
module psd_mem #(
   parameter int DW = 4,
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          re_i,
   input  logic [AW-1:0] raddr_i,
   output logic [DW-1:0] rdata_o
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] cell_q [DEPTH];

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
      always_ff @(posedge clk) begin
         if (we_i && (waddr_i == AW'(gi))) begin
            cell_q[gi] <= wdata_i;
         end
      end
   end

   assign rdata_o = cell_q[raddr_i];

   // R2
   port_clash_chk: assert property (@(posedge clk) disable iff (rst)
      (we_i && re_i) |-> (waddr_i != raddr_i));
endmodule

// File: rtl/psd_ctrl.sv
module psd_ctrl
   import psd_pkg::*;
#(
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start_i,
   input  logic          stop_i,
   input  logic [AW-1:0] dly_i,
   output logic          mem_we_o,
   output logic [AW-1:0] waddr_o,
   output logic          mem_re_o,
   output logic [AW-1:0] raddr_o,
   output logic          bypass_o,
   output logic          valid_o
);
   localparam int         DEPTH = 1 << AW;
   localparam logic [AW:0] MAXD = (AW+1)'(DEPTH - 1);

   psd_state_e    state_q, state_n;
   logic [AW-1:0] dly_q, wr_q, rd_q;
   logic          up_q;
   logic [AW:0]   pend_q, pend_n;
   logic          active, rd_live, byp, we, re, pass;

   always_comb begin
      byp     = (dly_q == '0);
      active  = (state_q != PS_IDLE);
      rd_live = up_q || (rd_q == '0);
      we      = (state_q == PS_RUN) && !stop_i && !start_i && !byp;
      pass    = (state_q == PS_RUN) && !stop_i && !start_i && byp;
      re      = active && !start_i && !byp && rd_live && (pend_q != '0);
      pend_n  = pend_q + (AW+1)'(we) - (AW+1)'(re);
      unique case (state_q)
         PS_RUN:   state_n = stop_i ? ((pend_n == '0) ? PS_IDLE : PS_DRAIN) : PS_RUN;
         PS_DRAIN: state_n = (pend_n == '0) ? PS_IDLE : PS_DRAIN;
         default:  state_n = PS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= PS_IDLE;
         dly_q   <= '0;
         wr_q    <= '0;
         rd_q    <= '0;
         up_q    <= 1'b0;
         pend_q  <= '0;
      end else if (start_i) begin
         state_q <= PS_RUN;
         dly_q   <= dly_i;
         wr_q    <= '0;
         rd_q    <= dly_i;
         up_q    <= 1'b0;
         pend_q  <= '0;
      end else if (active) begin
         wr_q   <= wr_q + AW'(we);
         pend_q <= pend_n;
         if (rd_live) begin
            if (re) begin
               rd_q <= rd_q + AW'(1);
               up_q <= 1'b1;
            end
         end else begin
            rd_q <= rd_q - AW'(1);
         end
         state_q <= state_n;
      end
   end

   assign mem_we_o = we;
   assign waddr_o  = wr_q;
   assign mem_re_o = re;
   assign raddr_o  = rd_q;
   assign bypass_o = byp;
   assign valid_o  = re || pass;

   // R6
   dly_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (active && !start_i) |=> $stable(dly_q));

   // R5
   drain_no_rerun_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == PS_DRAIN && !start_i) |=> (state_q != PS_RUN));

   // R2
   pend_bound_chk: assert property (@(posedge clk) disable iff (rst)
      pend_q <= MAXD);
endmodule

// File: rtl/prog_stream_delay.sv
module prog_stream_delay #(
   parameter int DW = 4,
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start_i,
   input  logic          stop_i,
   input  logic [AW-1:0] dly_i,
   input  logic [DW-1:0] din_i,
   output logic [DW-1:0] dout_o,
   output logic          valid_o
);
   if (DW < 1 || AW < 1 || AW > 10) begin : g_bad_param
      $error("prog_stream_delay: DW must be >= 1 and AW in 1..10");
   end

   logic          mem_we, mem_re, byp, vld;
   logic [AW-1:0] waddr, raddr;
   logic [DW-1:0] rdata;

   psd_ctrl #(.AW(AW)) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .start_i  (start_i),
      .stop_i   (stop_i),
      .dly_i    (dly_i),
      .mem_we_o (mem_we),
      .waddr_o  (waddr),
      .mem_re_o (mem_re),
      .raddr_o  (raddr),
      .bypass_o (byp),
      .valid_o  (vld)
   );

   psd_mem #(.DW(DW), .AW(AW)) u_mem (
      .clk     (clk),
      .rst     (rst),
      .we_i    (mem_we),
      .waddr_i (waddr),
      .wdata_i (din_i),
      .re_i    (mem_re),
      .raddr_i (raddr),
      .rdata_o (rdata)
   );

   assign valid_o = vld;
   assign dout_o  = vld ? (byp ? din_i : rdata) : '0;

   // R3
   bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
      (byp && valid_o) |-> (dout_o == din_i));

   // R4
   start_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      start_i |-> !valid_o);
endmodule

// File: tb/prog_stream_delay_bench.sv
`timescale 1ns/100ps
module prog_stream_delay_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start = 1'b0, stop = 1'b0;
   logic [3:0] dly = '0, din = '0;
   logic [3:0] dout;
   logic       valid;

   int  n_run = 0, n_fail = 0;
   bit  done = 0;
   bit  m_act = 0, m_stopped = 0;
   int  m_c = 0, m_d = 0, m_s = 0;
   logic [3:0] hist [0:255];
   string ovr = "";

   always #2 clk = ~clk;

   prog_stream_delay u_prog_stream_delay (
      .clk(clk), .rst(rst), .start_i(start), .stop_i(stop),
      .dly_i(dly), .din_i(din), .dout_o(dout), .valid_o(valid)
   );

   function automatic string pick_tag(input bit ev, input bit st, input bit sp);
      if (ovr != "") return ovr;
      if (st) return m_act ? "R8" : "R4";
      if (sp && (!m_act || m_stopped)) return "R9";
      if (!m_act) return "R1";
      if (ev) return (m_d == 0) ? "R3" : (m_stopped ? "R5" : "R2");
      if (m_c < m_d) return "R4";
      return "R5";
   endfunction

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
      end
   endtask

   task automatic step(input bit st, input bit sp, input logic [3:0] dl, input logic [3:0] dn);
      bit ev;
      int ed, k, lim;
      string tg;
      @(posedge clk); #0.5;
      start = st; stop = sp; dly = dl; din = dn;
      @(negedge clk);
      ev = 0; ed = 0;
      if (!st && m_act) begin
         k   = m_c - m_d;
         lim = m_stopped ? m_s : (sp ? m_c : m_c + 1);
         if (k >= 0 && k < lim) begin
            ev = 1;
            ed = (k == m_c) ? int'(dn) : int'(hist[k % 256]);
         end
      end
      tg = pick_tag(ev, st, sp);
      check(tg, "valid", int'(valid), int'(ev));
      check(ev ? tg : "R7", "dout", int'(dout), ed);
      if (st) begin
         m_act = 1; m_c = 0; m_d = int'(dl); m_stopped = 0;
      end else if (m_act) begin
         if (!m_stopped) begin
            if (sp) begin m_stopped = 1; m_s = m_c; end
            else hist[m_c % 256] = dn;
         end
         m_c++;
         if (m_stopped && (m_c - m_d) >= m_s) m_act = 0;
      end
   endtask

   task automatic stream(input int d, input int len, input bit restart_end);
      step(1, 0, 4'(d), 4'($urandom_range(0, 15)));
      for (int i = 0; i < len; i++)
         step(0, 0, (ovr == "R6") ? 4'(d ^ 5) : 4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)));
      if (restart_end) return;
      step(0, 1, 4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)));
      for (int i = 0; i < 18; i++)
         step(0, ($urandom_range(0, 5) == 0), 4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)));
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      #0.5 rst = 1'b0;
      @(negedge clk);
      check("R1", "valid after reset", int'(valid), 0);
      check("R1", "dout after reset", int'(dout), 0);
      step(0, 1, 4'd3, 4'd9);
      step(0, 0, 4'd3, 4'd9);
      stream(0, 10, 0);
      stream(1, 6, 0);
      stream(15, 20, 0);
      stream(15, 4, 0);
      stream(7, 0, 0);
      stream(5, 5, 0);
      ovr = "R6";
      stream(6, 14, 0);
      ovr = "R8";
      stream(4, 9, 1);
      ovr = "";
      stream(2, 8, 0);
      for (int r = 0; r < 60; r++)
         stream($urandom_range(0, 15), $urandom_range(0, 40), ($urandom_range(0, 4) == 0));
      step(0, 1, 4'd0, 4'd0);
      for (int i = 0; i < 20; i++) step(0, 0, 4'd1, 4'd3);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got hung expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule